// File: doc/BRIEF.md
# Oscillator Entropy Accumulator and Conditioning Sequencer

This block turns jitter from a bank of free-running oscillators into 64-bit random words. Each clock it XORs a selected subset of the synchronized oscillator bits onto a 128-bit linear feedback shift register. Time is split into fixed accumulation windows. When a window closes, the register state is either offered to an external conditioning hash core through a start/done handshake, or, in raw mode, sampled directly as output.

Two configuration bits steer the block. The entropy-enable bit cuts the oscillators off, so the register runs from its reset seed alone and the hash sees a repeatable input that software can use as a self-test. The raw-mode bit bypasses the hash. Any change to either bit restarts the window timing. The first word after reset or after such a change appears only once two whole windows have passed. A consumer reads a word by pulsing a read strobe while the valid flag is high.

Top module: `rosc_entropy_seq`

## Requirements
- R1: After reset the register holds 128'h0123456789ABCDEFFEDCBA9876543210. Each clock it becomes {state[126:0], f} XOR injection, where f is the XOR of state bits 127, 125, 100 and 98.
- R2: When entropy is enabled, the injection is osc_bits with lanes 125 to 127 forced to zero, so exactly 125 lanes (0 to 124) feed the register.
- R3: A window lasts 81 clocks. In conditioned mode, hash_start is high for one clock after each window closes (clocks 81, 162, ... after a restart), and hash_msg then carries the register state of the window's last clock.
- R4: In conditioned mode, each window close from the second onward publishes hash_digest_hi, as captured on hash_done for the hash started at the previous window close.
- R5: rnd_valid stays low for the first 161 clocks after reset or a restart. The earliest word is published on clock 162.
- R6: In raw mode, no hash_start is issued. Each window close from the second onward publishes the upper 64 bits (127:64) of the register state from the window's last clock.
- R7: rnd_valid stays high, with rnd_word unchanged, until a clock on which rd_strobe is high. It then falls on the next clock unless a new word is published on that clock.
- R8: A word that has not been read is replaced by the next published word, and rnd_valid stays high.
- R9: A cfg_we that changes either bit restarts window timing, clears rnd_valid, and discards any hash result still pending from before the change.
- R10: During reset rnd_valid, rnd_word and hash_start are zero, and both configuration bits are clear (entropy off, conditioned mode).
- R11: While entropy is disabled, osc_bits has no effect on the register sequence or on any output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_bits | input | 128 | Synchronized oscillator samples |
| cfg_we | input | 1 | Write strobe for the configuration bits |
| cfg_ent_en | input | 1 | Entropy-enable value to write |
| cfg_raw_mode | input | 1 | Raw-mode value to write |
| rd_strobe | input | 1 | Consumer read of the current word |
| hash_start | output | 1 | One-clock start pulse to the hash core |
| hash_msg | output | 128 | Register snapshot handed to the hash core |
| hash_done | input | 1 | Hash core result strobe |
| hash_digest_hi | input | 64 | Upper 64 bits of the 160-bit digest |
| rnd_word | output | 64 | Published random word |
| rnd_valid | output | 1 | rnd_word holds an unread word |

## Verification
The assertions check the local invariants on every clock:
- the window counter stays in range;
- the start pulse lasts one clock and never occurs in raw mode;
- valid is never high before the warm-up completes;
- the word changes only at a window close;
- valid holds or clears correctly around reads and restarts.

Only the bench's scenarios can show that the register sequence matches the seed and polynomial, that lanes 125 to 127 and disabled entropy leave the words untouched, that the right digest lands in the right window, and that a hash result abandoned by a restart is dropped.

// File: rtl/rosc_pkg.sv
package rosc_pkg;

    // Configuration register contents
    typedef struct packed {
        logic ent_en;
        logic raw_mode;
    } rosc_ctl_t;

    // Reset value: entropy off, conditioned path
    localparam rosc_ctl_t CTL_RST = '{ent_en: 1'b0, raw_mode: 1'b0};

endpackage

// File: rtl/rosc_lfsr.sv
// Accumulation register: Fibonacci shift with a masked oscillator injection.
module rosc_lfsr #(
    parameter int              W         = 128,
    parameter logic [W-1:0]    SEED      = {W{1'b1}},
    parameter logic [W-1:0]    TAP_MASK  = {W{1'b0}},
    parameter logic [W-1:0]    LANE_MASK = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ent_en,
    input  logic [W-1:0] osc_in,
    output logic [W-1:0] state
);

    typedef struct packed {
        logic [W-1:0] st;
    } lfsr_s;

    lfsr_s        r_q, r_d;
    logic [W-1:0] inj;
    logic         fb;

    // Per-lane gating: ignored lanes are masked off by constant
    for (genvar i = 0; i < W; i++) begin : g_lane
        assign inj[i] = ent_en & osc_in[i] & LANE_MASK[i];
    end

    always_comb begin
        r_d    = r_q;
        fb     = ^(r_q.st & TAP_MASK);
        r_d.st = {r_q.st[W-2:0], fb} ^ inj;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: SEED};
        else        r_q <= r_d;
    end

    assign state = r_q.st;

endmodule

// File: rtl/rosc_window.sv
// Window timer and warm-up tracking.
module rosc_window #(
    parameter int  WIN  = 81,
    parameter int  WARM = 2,
    localparam int CW   = (WIN > 1) ? $clog2(WIN) : 1,
    localparam int NW   = $clog2(WARM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic          win_end,
    output logic          pub_ok,
    output logic          warm_done,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] LAST    = CW'(WIN - 1);
    localparam logic [NW-1:0] WFULL   = NW'(WARM);
    localparam logic [NW-1:0] PUB_MIN = NW'(WARM - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [NW-1:0] wins;
    } win_s;

    win_s w_q, w_d;

    always_comb begin
        w_d       = w_q;
        win_end   = (w_q.cnt == LAST);
        // publish on the close of the final warm-up window and every close after
        pub_ok    = win_end && (w_q.wins >= PUB_MIN);
        warm_done = (w_q.wins == WFULL);
        if (restart) begin
            w_d = '0;
        end else if (win_end) begin
            w_d.cnt = '0;
            if (w_q.wins != WFULL) w_d.wins = w_q.wins + 1'b1;
        end else begin
            w_d.cnt = w_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign cnt_o = w_q.cnt;

endmodule

// File: rtl/rosc_out.sv
// Hash handshake, digest holding register and published word.
module rosc_out #(
    parameter int LW = 128,
    parameter int OW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          win_end,
    input  logic          pub_ok,
    input  logic          raw_mode,
    input  logic [LW-1:0] lfsr,
    input  logic          hash_done,
    input  logic [OW-1:0] dig_hi,
    input  logic          rd,
    output logic          hash_start,
    output logic [LW-1:0] hash_msg,
    output logic [OW-1:0] word,
    output logic          valid
);

    typedef struct packed {
        logic          start;
        logic [LW-1:0] msg;
        logic          ours;   // a hash issued since the last restart is in flight
        logic          have;   // digest waiting for the next window close
        logic [OW-1:0] dig;
        logic [OW-1:0] word;
        logic          valid;
    } out_s;

    out_s o_q, o_d;

    always_comb begin
        o_d       = o_q;
        o_d.start = 1'b0;
        if (restart) begin
            o_d.ours  = 1'b0;
            o_d.have  = 1'b0;
            o_d.valid = 1'b0;
        end else begin
            if (rd && o_q.valid) o_d.valid = 1'b0;
            if (pub_ok) begin
                if (raw_mode) begin
                    o_d.word  = lfsr[LW-1 -: OW];
                    o_d.valid = 1'b1;
                end else if (o_q.have) begin
                    o_d.word  = o_q.dig;
                    o_d.valid = 1'b1;
                    o_d.have  = 1'b0;
                end
            end
            if (hash_done && o_q.ours) begin
                o_d.dig  = dig_hi;
                o_d.have = 1'b1;
                o_d.ours = 1'b0;
            end
            if (win_end && !raw_mode) begin
                o_d.start = 1'b1;
                o_d.msg   = lfsr;
                o_d.ours  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign hash_start = o_q.start;
    assign hash_msg   = o_q.msg;
    assign word       = o_q.word;
    assign valid      = o_q.valid;

endmodule

// File: rtl/rosc_entropy_seq.sv
module rosc_entropy_seq
    import rosc_pkg::*;
#(
    parameter int LFSR_W    = 128,
    parameter int OUT_W     = 64,
    parameter int WIN_LEN   = 81,
    parameter int WARM_WIN  = 2,
    parameter int IGN_LANES = 3,
    parameter logic [LFSR_W-1:0] SEED     = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
    parameter logic [LFSR_W-1:0] TAP_MASK = {1'b1, 1'b0, 1'b1, 24'd0, 1'b1, 1'b0, 1'b1, 98'd0}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LFSR_W-1:0] osc_bits,
    input  logic              cfg_we,
    input  logic              cfg_ent_en,
    input  logic              cfg_raw_mode,
    input  logic              rd_strobe,
    output logic              hash_start,
    output logic [LFSR_W-1:0] hash_msg,
    input  logic              hash_done,
    input  logic [OUT_W-1:0]  hash_digest_hi,
    output logic [OUT_W-1:0]  rnd_word,
    output logic              rnd_valid
);

    localparam logic [LFSR_W-1:0] LANE_MASK = {LFSR_W{1'b1}} >> IGN_LANES;
    localparam int                CW        = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

    typedef struct packed {
        rosc_ctl_t ctl;
    } top_s;

    top_s              t_q, t_d;
    rosc_ctl_t         cfg_new;
    logic              restart;
    logic              raw_q;
    logic              win_end, pub_ok, warm_done;
    logic [CW-1:0]     win_cnt;
    logic [LFSR_W-1:0] lfsr_st;

    // Only a write that actually changes a bit counts as a restart
    always_comb begin
        t_d     = t_q;
        cfg_new = '{ent_en: cfg_ent_en, raw_mode: cfg_raw_mode};
        restart = cfg_we && (cfg_new != t_q.ctl);
        if (restart) t_d.ctl = cfg_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{ctl: CTL_RST};
        else        t_q <= t_d;
    end

    assign raw_q = t_q.ctl.raw_mode;

    rosc_lfsr #(
        .W         (LFSR_W),
        .SEED      (SEED),
        .TAP_MASK  (TAP_MASK),
        .LANE_MASK (LANE_MASK)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ent_en (t_q.ctl.ent_en),
        .osc_in (osc_bits),
        .state  (lfsr_st)
    );

    rosc_window #(
        .WIN  (WIN_LEN),
        .WARM (WARM_WIN)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .win_end   (win_end),
        .pub_ok    (pub_ok),
        .warm_done (warm_done),
        .cnt_o     (win_cnt)
    );

    rosc_out #(
        .LW (LFSR_W),
        .OW (OUT_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .win_end    (win_end),
        .pub_ok     (pub_ok),
        .raw_mode   (raw_q),
        .lfsr       (lfsr_st),
        .hash_done  (hash_done),
        .dig_hi     (hash_digest_hi),
        .rd         (rd_strobe),
        .hash_start (hash_start),
        .hash_msg   (hash_msg),
        .word       (rnd_word),
        .valid      (rnd_valid)
    );

endmodule

// File: rtl/rosc_seq_chk.sv
module rosc_seq_chk #(
    parameter int WIN = 81,
    parameter int OW  = 64,
    parameter int CW  = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          restart,
    input logic          win_end,
    input logic          warm_done,
    input logic          raw_q,
    input logic          hash_start,
    input logic          rd_strobe,
    input logic          rnd_valid,
    input logic [OW-1:0] rnd_word,
    input logic [CW-1:0] win_cnt
);

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= CW'(WIN - 1));

    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |=> !hash_start);

    p_no_start_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |-> !raw_q);

    p_warmup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_valid |-> warm_done);

    p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_valid && rd_strobe && !win_end) |=> !rnd_valid);

    p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rnd_valid && !rd_strobe && !restart) |=> rnd_valid);

    p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(rnd_word));

    p_restart_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!rnd_valid && !hash_start));

endmodule

bind rosc_entropy_seq rosc_seq_chk #(
    .WIN (WIN_LEN),
    .OW  (OUT_W),
    .CW  (CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .win_end    (win_end),
    .warm_done  (warm_done),
    .raw_q      (raw_q),
    .hash_start (hash_start),
    .rd_strobe  (rd_strobe),
    .rnd_valid  (rnd_valid),
    .rnd_word   (rnd_word),
    .win_cnt    (win_cnt)
);

// File: tb/sim_rosc_entropy_seq.sv
`timescale 1ns/1ps
module sim_rosc_entropy_seq;

    localparam logic [127:0] SEED_V   = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    localparam logic [127:0] LANES_V  = {3'b000, {125{1'b1}}};
    localparam logic [127:0] TOP3_V   = {3'b111, 125'd0};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] osc_bits = '0;
    logic         cfg_we = 1'b0, cfg_ent_en = 1'b0, cfg_raw_mode = 1'b0;
    logic         rd_strobe = 1'b0;
    logic         hash_start;
    logic [127:0] hash_msg;
    logic         hash_done = 1'b0;
    logic [63:0]  hash_digest_hi = '0;
    logic [63:0]  rnd_word;
    logic         rnd_valid;

    always #10 clk = ~clk;   // 50 MHz

    rosc_entropy_seq u0 (
        .clk(clk), .rst_n(rst_n), .osc_bits(osc_bits), .cfg_we(cfg_we),
        .cfg_ent_en(cfg_ent_en), .cfg_raw_mode(cfg_raw_mode), .rd_strobe(rd_strobe),
        .hash_start(hash_start), .hash_msg(hash_msg), .hash_done(hash_done),
        .hash_digest_hi(hash_digest_hi), .rnd_word(rnd_word), .rnd_valid(rnd_valid)
    );

    int checks = 0, errors = 0, cyc = 0;

    // bench-side model state
    logic [127:0] m_lfsr, m_prev;
    logic         m_ent, m_raw;
    int           k;
    logic         e_valid, e_have, e_ours;
    logic [63:0]  e_word, e_dig;
    logic [127:0] hb_msg;
    int           hb_cnt;
    // stimulus control
    int           osc_mode = 0, rd_pct = 0;
    logic         cfg_req = 1'b0, req_ent = 1'b0, req_raw = 1'b0;

    function automatic logic [127:0] step(logic [127:0] s, logic [127:0] o, logic en);
        logic f;
        f = s[127] ^ s[125] ^ s[100] ^ s[98];
        return {s[126:0], f} ^ (en ? (o & LANES_V) : 128'd0);
    endfunction

    function automatic logic [63:0] hmix(logic [127:0] m);
        return m[127:64] ^ {m[31:0], m[63:32]} ^ 64'hC3A5_5A3C_0F0F_F0F0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at k=%0d: actual %h expected %h", tag, k, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic restart_e, pub, over, exp_start;
        string wtag;
        if (!rst_n) begin
            m_lfsr = SEED_V; m_prev = SEED_V; m_ent = 1'b0; m_raw = 1'b0; k = 0;
            e_valid = 1'b0; e_have = 1'b0; e_ours = 1'b0; e_word = '0; e_dig = '0;
            hb_cnt = 0; hash_done = 1'b0;
        end else begin
            restart_e = cfg_we && ({cfg_ent_en, cfg_raw_mode} != {m_ent, m_raw});
            m_prev = m_lfsr;
            m_lfsr = step(m_lfsr, osc_bits, m_ent);
            over = 1'b0;
            exp_start = 1'b0;
            if (restart_e) begin
                k = 0; m_ent = cfg_ent_en; m_raw = cfg_raw_mode;
                e_valid = 1'b0; e_have = 1'b0; e_ours = 1'b0;
            end else begin
                k++;
                pub = (k >= 162) && (k % 81 == 0);
                if (rd_strobe && e_valid) e_valid = 1'b0;
                if (pub) begin
                    if (m_raw) begin
                        over = e_valid; e_word = m_prev[127:64]; e_valid = 1'b1;
                    end else if (e_have) begin
                        over = e_valid; e_word = e_dig; e_valid = 1'b1; e_have = 1'b0;
                    end
                end
                if (hash_done && e_ours) begin
                    e_dig = hash_digest_hi; e_have = 1'b1; e_ours = 1'b0;
                end
                exp_start = (k % 81 == 0) && !m_raw;
                if (exp_start) e_ours = 1'b1;
            end
            // hash start pulse: R3 in conditioned mode, R6 in raw mode
            chk(hash_start == exp_start, m_raw ? "R6" : "R3", 128'(hash_start), 128'(exp_start));
            if (exp_start && hash_start)
                chk(hash_msg == m_prev, m_ent ? "R3" : "R1", hash_msg, m_prev);
            chk(rnd_valid == e_valid, (k == 0) ? "R9" : ((k < 162) ? "R5" : "R7"),
                128'(rnd_valid), 128'(e_valid));
            if (over)                 wtag = "R8";
            else if (!m_raw)          wtag = "R4";
            else if (m_ent)           wtag = "R2";
            else                      wtag = "R11";
            chk(rnd_word == e_word, wtag, 128'(rnd_word), 128'(e_word));
            // hash core model
            hash_done = 1'b0;
            if (hb_cnt != 0) begin
                hb_cnt--;
                if (hb_cnt == 0) begin
                    hash_done = 1'b1;
                    hash_digest_hi = hmix(hb_msg);
                end
            end
            if (hash_start) begin
                hb_msg = hash_msg;
                hb_cnt = 5 + int'($urandom % 40);
            end
        end
        // next stimulus
        cfg_we = 1'b0;
        if (cfg_req && rst_n) begin
            cfg_we = 1'b1; cfg_ent_en = req_ent; cfg_raw_mode = req_raw; cfg_req = 1'b0;
        end
        rd_strobe = (int'($urandom % 100) < rd_pct);
        case (osc_mode)
            1:       osc_bits = {$urandom, $urandom, $urandom, $urandom};
            2:       osc_bits = {$urandom, $urandom, $urandom, $urandom} & TOP3_V;
            default: osc_bits = '0;
        endcase
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic set_cfg(input logic en, input logic raw);
        @(posedge clk);
        req_ent = en; req_raw = raw; cfg_req = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R10: reset state
        #2;
        chk(rnd_valid == 1'b0, "R10", 128'(rnd_valid), 128'd0);
        chk(rnd_word == 64'd0, "R10", 128'(rnd_word), 128'd0);
        chk(hash_start == 1'b0, "R10", 128'(hash_start), 128'd0);
        #3 rst_n = 1'b1;
        // A: entropy off, conditioned, oscillators toggling, no reads (R1, R4, R5, R8, R11)
        osc_mode = 1; rd_pct = 0;
        repeat (420) @(posedge clk);
        // B: raw mode, entropy off (R6, R11, R7)
        set_cfg(1'b0, 1'b1); rd_pct = 50;
        repeat (420) @(posedge clk);
        // C: raw mode with entropy (R2)
        set_cfg(1'b1, 1'b1);
        repeat (420) @(posedge clk);
        // D: only the ignored lanes toggle (R2)
        osc_mode = 2;
        repeat (420) @(posedge clk);
        // E: conditioned with entropy, random reads (R4, R7, R8)
        osc_mode = 1; rd_pct = 30;
        set_cfg(1'b1, 1'b0);
        repeat (500) @(posedge clk);
        // F: restart while a hash is in flight (R9)
        do @(negedge clk); while (!hash_start);
        repeat (3) @(posedge clk);
        set_cfg(1'b0, 1'b0);
        repeat (420) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule